// File: doc/BRIEF.md
# Block-edge overlap smoothing filter

This block softens the seam between two neighbouring coded blocks. It sees one line of four 8-bit unsigned samples per cycle. Each line crosses the seam: two samples lie on the near side (`pixA`, `pixB`) and two on the far side (`pixC`, `pixD`). The seam lies between `pixB` and `pixC`. From the line it forms an outer correction and an inner correction. It returns four corrected samples one clock later.

An edge is always eight consecutive lines. A rounding bit changes from line to line along the edge, and a start pulse re-aligns the rounding bit and the line count to the first line of a new edge. A direction input marks the edge as horizontal or vertical. That marking is only passed along with the result, so both orientations use the same arithmetic. Fetching samples from memory and choosing which edges to smooth are left to the surrounding logic.

Top module: `edge_blend_filter`

## Requirements
- R1: After reset, `outValid` and `edgeDone` are 0 and all four sample outputs are 0.
- R2: `outValid` equals the `inValid` of the previous cycle, and a line accepted in cycle n appears on the sample outputs in cycle n+1.
- R3: With the rounding bit r, the outer correction is k = floor((A - D + 3 + r) / 8). `outA` is the low 8 bits of A - k and `outD` is the low 8 bits of D + k. Neither is saturated.
- R4: The inner correction is m = floor((A - D + B - C + 4 - r) / 8). `outB` = B - m and `outC` = C + m, each saturated to the range 0..255.
- R5: The rounding bit is 1 on the first accepted line of an edge and alternates 1, 0, 1, 0 on each following accepted line.
- R6: An accepted line with `startEdge` high is always treated as line 0 with r = 1, even in the middle of an edge. A `startEdge` pulse without `inValid` resets the count so that the next accepted line is line 0.
- R7: `edgeDone` is high for exactly one cycle, together with the result of the eighth accepted line of an edge. After the eighth line the count wraps to line 0 with r = 1.
- R8: `outDirVert` carries the `dirVert` value of the line shown. The sample results do not depend on `dirVert`.
- R9: A cycle with `inValid` low advances neither the line count nor the rounding bit, and the sample outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | A line is presented this cycle |
| startEdge | input | 1 | Marks the first line of a new edge |
| dirVert | input | 1 | Edge orientation tag (1 = vertical) |
| pixA | input | 8 | Outer sample, near side |
| pixB | input | 8 | Inner sample, near side |
| pixC | input | 8 | Inner sample, far side |
| pixD | input | 8 | Outer sample, far side |
| outValid | output | 1 | Corrected line is valid |
| outDirVert | output | 1 | Orientation tag of the corrected line |
| outA | output | 8 | Corrected outer sample, near side |
| outB | output | 8 | Corrected inner sample, near side |
| outC | output | 8 | Corrected inner sample, far side |
| outD | output | 8 | Corrected outer sample, far side |
| edgeDone | output | 1 | One-cycle pulse with the eighth line's result |

## Verification
The bench builds the block with its default parameters: 8-bit samples and eight lines per edge. At that sample width the difference terms can reach almost twice the sample range, so extreme opposite-side values drive both inner outputs into low and high saturation. With an eight-line edge, the done pulse and the wrap of the count occur often in a random run that also contains idle gaps and start pulses in the middle of an edge. Directed lines with A - D = 4 expose the rounding bit directly on `outA`.

// File: rtl/edge_blend_pkg.sv
package edge_blend_pkg;
  // Strobes from the line sequencer to the arithmetic path
  typedef struct packed {
    logic loadLine;  // a line is accepted this cycle
    logic rndBit;    // rounding bit for that line
    logic lastLine;  // that line closes the edge
  } ctrlStrobes_t;
endpackage

// File: rtl/edge_blend_ctrl.sv
module edge_blend_ctrl
  import edge_blend_pkg::*;
#(
  parameter int LINES = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inValid,
  input  logic         startEdge,
  output ctrlStrobes_t strb
);
  localparam int CNT_W = (LINES > 1) ? $clog2(LINES) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(LINES - 1);

  logic [CNT_W-1:0] lineIdx;
  logic             rndState;
  logic [CNT_W-1:0] effIdx;
  logic             effRnd;

  // A start pulse overrides the stored position for the current line
  always_comb begin
    effIdx = startEdge ? '0 : lineIdx;
    effRnd = startEdge ? 1'b1 : rndState;
    strb.loadLine = inValid;
    strb.rndBit   = effRnd;
    strb.lastLine = (effIdx == LAST_IDX);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lineIdx  <= '0;
      rndState <= 1'b1;
    end else if (inValid) begin
      if (effIdx == LAST_IDX) begin
        lineIdx  <= '0;
        rndState <= 1'b1;
      end else begin
        lineIdx  <= effIdx + 1'b1;
        rndState <= ~effRnd;
      end
    end else if (startEdge) begin
      lineIdx  <= '0;
      rndState <= 1'b1;
    end
  end
endmodule

// File: rtl/edge_blend_dp.sv
module edge_blend_dp
  import edge_blend_pkg::*;
#(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ctrlStrobes_t     strb,
  input  logic             dirVert,
  input  logic [PIX_W-1:0] pixA,
  input  logic [PIX_W-1:0] pixB,
  input  logic [PIX_W-1:0] pixC,
  input  logic [PIX_W-1:0] pixD,
  output logic             outValid,
  output logic             outDirVert,
  output logic [PIX_W-1:0] outA,
  output logic [PIX_W-1:0] outB,
  output logic [PIX_W-1:0] outC,
  output logic [PIX_W-1:0] outD,
  output logic             edgeDone
);
  // Three guard bits: sign plus headroom for a sum of two differences
  localparam int CALC_W = PIX_W + 3;
  localparam int EXT_W  = CALC_W - PIX_W;
  localparam logic signed [CALC_W-1:0] MAXV = CALC_W'((1 << PIX_W) - 1);
  localparam logic signed [CALC_W-1:0] OFS_OUT = CALC_W'(3);
  localparam logic signed [CALC_W-1:0] OFS_IN  = CALC_W'(4);

  function automatic logic [PIX_W-1:0] satPix(input logic signed [CALC_W-1:0] v);
    if (v < 0)         satPix = '0;
    else if (v > MAXV) satPix = MAXV[PIX_W-1:0];
    else               satPix = v[PIX_W-1:0];
  endfunction

  logic signed [CALC_W-1:0] sA, sB, sC, sD, sRnd;
  logic signed [CALC_W-1:0] outerCorr, innerCorr;
  logic signed [CALC_W-1:0] nearOuter, farOuter, nearInner, farInner;

  always_comb begin
    sA   = signed'({{EXT_W{1'b0}}, pixA});
    sB   = signed'({{EXT_W{1'b0}}, pixB});
    sC   = signed'({{EXT_W{1'b0}}, pixC});
    sD   = signed'({{EXT_W{1'b0}}, pixD});
    sRnd = signed'({{(CALC_W-1){1'b0}}, strb.rndBit});
    outerCorr = (sA - sD + OFS_OUT + sRnd) >>> 3;
    innerCorr = (sA - sD + sB - sC + OFS_IN - sRnd) >>> 3;
    nearOuter = sA - outerCorr;
    farOuter  = sD + outerCorr;
    nearInner = sB - innerCorr;
    farInner  = sC + innerCorr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid   <= 1'b0;
      edgeDone   <= 1'b0;
      outDirVert <= 1'b0;
      outA       <= '0;
      outB       <= '0;
      outC       <= '0;
      outD       <= '0;
    end else begin
      outValid <= strb.loadLine;
      edgeDone <= strb.loadLine & strb.lastLine;
      if (strb.loadLine) begin
        outDirVert <= dirVert;
        outA       <= nearOuter[PIX_W-1:0];
        outB       <= satPix(nearInner);
        outC       <= satPix(farInner);
        outD       <= farOuter[PIX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/edge_blend_filter.sv
module edge_blend_filter
  import edge_blend_pkg::*;
#(
  parameter int PIX_W = 8,
  parameter int LINES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inValid,
  input  logic             startEdge,
  input  logic             dirVert,
  input  logic [PIX_W-1:0] pixA,
  input  logic [PIX_W-1:0] pixB,
  input  logic [PIX_W-1:0] pixC,
  input  logic [PIX_W-1:0] pixD,
  output logic             outValid,
  output logic             outDirVert,
  output logic [PIX_W-1:0] outA,
  output logic [PIX_W-1:0] outB,
  output logic [PIX_W-1:0] outC,
  output logic [PIX_W-1:0] outD,
  output logic             edgeDone
);
  ctrlStrobes_t strb;

  edge_blend_ctrl #(.LINES(LINES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .startEdge(startEdge), .strb(strb)
  );

  edge_blend_dp #(.PIX_W(PIX_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .dirVert(dirVert),
    .pixA(pixA), .pixB(pixB), .pixC(pixC), .pixD(pixD),
    .outValid(outValid), .outDirVert(outDirVert),
    .outA(outA), .outB(outB), .outC(outC), .outD(outD), .edgeDone(edgeDone)
  );
endmodule

// File: rtl/edge_blend_checker.sv
module edge_blend_checker #(
  parameter int PIX_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             inValid,
  input logic             dirVert,
  input logic             outValid,
  input logic             outDirVert,
  input logic [PIX_W-1:0] outA,
  input logic [PIX_W-1:0] outB,
  input logic [PIX_W-1:0] outC,
  input logic [PIX_W-1:0] outD,
  input logic             edgeDone
);
  p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);
  p_valid_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);
  p_done_needs_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    edgeDone |-> outValid);
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    edgeDone |=> !edgeDone);
  p_dir_tag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> (outDirVert == $past(dirVert)));
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> ($stable(outA) && $stable(outB) && $stable(outC) && $stable(outD)));
endmodule

bind edge_blend_filter edge_blend_checker #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .inValid(inValid), .dirVert(dirVert),
  .outValid(outValid), .outDirVert(outDirVert),
  .outA(outA), .outB(outB), .outC(outC), .outD(outD), .edgeDone(edgeDone)
);

// File: tb/sim_edge_blend_filter.sv
module sim_edge_blend_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0, startEdge = 1'b0, dirVert = 1'b0;
  logic [7:0] pixA = '0, pixB = '0, pixC = '0, pixD = '0;
  logic outValid, outDirVert, edgeDone;
  logic [7:0] outA, outB, outC, outD;

  int nTests = 0;
  int nFail = 0;
  int modelIdx = 0;
  int modelRnd = 1;
  logic [7:0] lastA = '0, lastB = '0, lastC = '0, lastD = '0;

  always #5 clk = ~clk;

  edge_blend_filter u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .startEdge(startEdge), .dirVert(dirVert),
    .pixA(pixA), .pixB(pixB), .pixC(pixC), .pixD(pixD),
    .outValid(outValid), .outDirVert(outDirVert),
    .outA(outA), .outB(outB), .outC(outC), .outD(outD), .edgeDone(edgeDone)
  );

  function automatic int floorDiv8(input int v);
    return (v >= 0) ? v / 8 : -((-v + 7) / 8);
  endfunction

  function automatic int sat(input int v);
    return (v < 0) ? 0 : (v > 255) ? 255 : v;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one line at the falling edge; check the result one cycle later
  task automatic sendLine(input int a, input int b, input int c, input int d,
                          input bit st, input bit dv);
    int r, k, m, eA, eB, eC, eD;
    bit eDone;
    if (st) begin modelIdx = 0; modelRnd = 1; end
    r = modelRnd;
    k = floorDiv8(a - d + 3 + r);
    m = floorDiv8(a - d + b - c + 4 - r);
    eA = (a - k) & 255;
    eD = (d + k) & 255;
    eB = sat(b - m);
    eC = sat(c + m);
    eDone = (modelIdx == 7);
    if (modelIdx == 7) begin modelIdx = 0; modelRnd = 1; end
    else begin modelIdx++; modelRnd = 1 - modelRnd; end
    pixA = 8'(a); pixB = 8'(b); pixC = 8'(c); pixD = 8'(d);
    startEdge = st; dirVert = dv; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0; startEdge = 1'b0;
    chk(outValid == 1'b1, "R2 outValid", int'(outValid), 1);
    chk(outA == 8'(eA), "R3 outA", int'(outA), eA);
    chk(outD == 8'(eD), "R3 outD", int'(outD), eD);
    chk(outB == 8'(eB), "R4 outB", int'(outB), eB);
    chk(outC == 8'(eC), "R4 outC", int'(outC), eC);
    chk(outDirVert == dv, "R8 outDirVert", int'(outDirVert), int'(dv));
    chk(edgeDone == eDone, "R7 edgeDone", int'(edgeDone), int'(eDone));
    lastA = outA; lastB = outB; lastC = outC; lastD = outD;
  endtask

  task automatic idleCycle(input bit st);
    startEdge = st; inValid = 1'b0;
    if (st) begin modelIdx = 0; modelRnd = 1; end
    @(negedge clk);
    startEdge = 1'b0;
    chk(outValid == 1'b0, "R2 outValid idle", int'(outValid), 0);
    chk(edgeDone == 1'b0, "R7 no done idle", int'(edgeDone), 0);
    chk({outA, outB, outC, outD} == {lastA, lastB, lastC, lastD}, "R9 hold",
        int'(outA), int'(lastA));
  endtask

  initial begin
    int seed;
    seed = 32'h1d2c;
    void'($urandom(seed));
    #1;
    chk(outValid == 1'b0, "R1 outValid", int'(outValid), 0);
    chk(edgeDone == 1'b0, "R1 edgeDone", int'(edgeDone), 0);
    chk({outA, outB, outC, outD} == 32'd0, "R1 samples", int'(outA), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5: A-D=4 puts the rounding bit on outA: r=1 -> 3, r=0 -> 4
    for (int i = 0; i < 8; i++) begin
      sendLine(4, 0, 0, 0, i == 0, 1'b0);
      chk(outA == ((i % 2 == 0) ? 8'd3 : 8'd4), "R5 rnd sequence", int'(outA),
          (i % 2 == 0) ? 3 : 4);
    end
    // R7: wrap gives r=1 on the next line
    sendLine(4, 0, 0, 0, 1'b0, 1'b1);
    chk(outA == 8'd3, "R7 wrap rnd", int'(outA), 3);
    // R9: idle gap does not advance the rounding bit (next expects r=0)
    idleCycle(1'b0);
    idleCycle(1'b0);
    sendLine(4, 0, 0, 0, 1'b0, 1'b0);
    chk(outA == 8'd4, "R9 rnd kept", int'(outA), 4);
    // R6: start in mid-edge forces r=1
    sendLine(4, 0, 0, 0, 1'b1, 1'b0);
    chk(outA == 8'd3, "R6 restart rnd", int'(outA), 3);
    // R6: start without valid
    sendLine(4, 0, 0, 0, 1'b0, 1'b0);
    idleCycle(1'b1);
    sendLine(4, 0, 0, 0, 1'b0, 1'b0);
    chk(outA == 8'd3, "R6 idle start", int'(outA), 3);

    // R4 saturation corners
    sendLine(255, 10, 0, 0, 1'b1, 1'b0);
    chk(outB == 8'd0, "R4 low clip", int'(outB), 0);
    sendLine(255, 250, 240, 0, 1'b0, 1'b1);
    chk(outC == 8'd255, "R4 high clip", int'(outC), 255);
    sendLine(0, 0, 255, 255, 1'b0, 1'b0);
    sendLine(0, 255, 0, 255, 1'b0, 1'b1);
    sendLine(255, 0, 255, 0, 1'b0, 1'b0);

    // Random lines with gaps and occasional restarts
    for (int n = 0; n < 400; n++) begin
      int sel;
      sel = int'($urandom_range(0, 19));
      if (sel == 0) idleCycle(1'b0);
      else if (sel == 1) idleCycle(1'b1);
      else sendLine(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                    int'($urandom_range(0, 255)), int'($urandom_range(0, 255)),
                    sel == 2, 1'($urandom_range(0, 1)));
    end

    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule